// File: doc/BRIEF.md
# Constant-Memory Checksum Locator

This block walks every word of a set of constant memory banks through one synchronous read port and builds two kinds of checksum from them. One full-width XOR of all words only answers whether the image has changed. A group of narrow positional checksums forms a Hamming arrangement. Positional checksum k folds each word down to one slice and XORs in only the words whose combined location has bit k set.

At the end of the walk the computed values are compared with reference values that were captured when the image was first loaded. If the full-width sum still matches, the block reports a clean pass and ignores the positional results. If it differs, the block raises an error and rebuilds the location of the damaged word from the positional mismatches, assuming exactly one word is wrong.

A learn mode runs the same walk but suppresses the verdict, so the sums on the outputs can be stored as the reference values. The banks are scanned bank-major, so the combined location is {bank, word}.

Top module: `csum_locator`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `error` and `bad_loc` are 0 until a scan completes.
- R2: A `start` sampled high while idle begins a scan that drives the combined location {`mem_sel`,`mem_addr`} with 0 in the first cycle after that edge, then one higher in each following cycle, covering every location of every bank exactly once.
- R3: `done` is high for exactly one cycle, beginning at the (N+2)-th rising edge after the edge that accepted `start`, where N is the total number of locations.
- R4: After `done`, `sum_total` equals the XOR of every word read.
- R5: After `done`, slice k of `sum_pos` (bits k*SLICE_W upward) equals the XOR, over all locations whose bit k is 1, of the word folded to SLICE_W bits. The fold is the XOR of its SLICE_W-bit slices taken from bit 0 upward, with the top slice zero-padded.
- R6: With learn off, when `sum_total` equals `ref_total` at the end of the scan, `error` is 0 and `bad_loc` is 0 whatever the positional comparison gives.
- R7: With learn off, when `sum_total` differs from `ref_total`, `error` is 1 and bit k of `bad_loc` is 1 exactly when positional slice k differs from its reference. For a single corrupted word, this yields that word's combined location.
- R8: A scan started with `learn` high reports `error` 0 and `bad_loc` 0 for any reference values, while still producing the R4 and R5 sums.
- R9: A `start` pulse during a scan has no effect: the scan continues, `done` keeps the R3 timing, and the results are those of the original scan.
- R10: `error` and `bad_loc` hold their verdict after `done` until the next accepted `start`, which clears them at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan when idle |
| learn | input | 1 | Sampled with start; suppresses the verdict |
| mem_sel | output | BANK_W | Bank select of the read port |
| mem_addr | output | WORD_W | Word address of the read port |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| ref_total | input | DATA_W | Reference full-width checksum |
| ref_pos | input | NPOS*SLICE_W | Reference positional checksums, slice k at bits k*SLICE_W |
| sum_total | output | DATA_W | Computed full-width checksum |
| sum_pos | output | NPOS*SLICE_W | Computed positional checksums |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Image differs from reference |
| bad_loc | output | NPOS | Rebuilt location of the damaged word |

## Verification
Random images are first scanned in learn mode. This separates the sum arithmetic (R4, R5) from the verdict logic, and it also checks address order and latency. Each image is then rescanned against its own sums, and then with one single-bit flip at random locations and at locations 0 and N-1. The flips tell a correct locator from one that drops or swaps location bits; location 0 is the case where every positional slice still matches. Corrupting only the positional references while the full sum matches separates R6 from R7. A second start injected mid-scan and a learn run over a damaged image check that the verdict is ignored or suppressed when it should be.

// File: rtl/csum_pkg.sv
package csum_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SCAN   = 2'd1,
        SQ_DRAIN  = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;
endpackage

// File: rtl/csum_seq.sv
module csum_seq
    import csum_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              acc_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              clr,
    output logic              fin,
    output logic              scanning
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              rd_valid;
        logic [ADDR_W-1:0] rd_addr;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        case (st_q.state)
            SQ_IDLE: begin
                if (start) begin
                    st_d.state = SQ_SCAN;
                    st_d.addr  = '0;
                end
            end
            SQ_SCAN: begin
                // the memory latches addr at this edge; its data is used next edge
                st_d.rd_valid = 1'b1;
                st_d.rd_addr  = st_q.addr;
                if (st_q.addr == LAST) begin
                    st_d.state = SQ_DRAIN;
                end else begin
                    st_d.addr = st_q.addr + 1'b1;
                end
            end
            SQ_DRAIN:  st_d.state = SQ_FINISH;
            SQ_FINISH: st_d.state = SQ_IDLE;
            default:   st_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SQ_IDLE, addr: '0, rd_valid: 1'b0, rd_addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr  = st_q.addr;
    assign acc_en   = st_q.rd_valid;
    assign acc_addr = st_q.rd_addr;
    assign clr      = start && (st_q.state == SQ_IDLE);
    assign fin      = (st_q.state == SQ_FINISH);
    assign scanning = (st_q.state == SQ_SCAN);
endmodule

// File: rtl/csum_fold.sv
module csum_fold #(
    parameter int DATA_W  = 36,
    parameter int SLICE_W = 6
) (
    input  logic [DATA_W-1:0]  word,
    output logic [SLICE_W-1:0] slice
);
    localparam int NSL  = (DATA_W + SLICE_W - 1) / SLICE_W;
    localparam int PADW = NSL * SLICE_W;

    logic [PADW-1:0]             padded;
    logic [NSL:0][SLICE_W-1:0]   chain;

    assign padded   = PADW'(word);
    assign chain[0] = '0;

    for (genvar i = 0; i < NSL; i++) begin : g_slice
        assign chain[i+1] = chain[i] ^ padded[i*SLICE_W +: SLICE_W];
    end

    assign slice = chain[NSL];
endmodule

// File: rtl/csum_locate.sv
module csum_locate #(
    parameter int DATA_W  = 36,
    parameter int SLICE_W = 6,
    parameter int NPOS    = 6
) (
    input  logic [DATA_W-1:0]       sum_total,
    input  logic [DATA_W-1:0]       ref_total,
    input  logic [NPOS*SLICE_W-1:0] sum_pos,
    input  logic [NPOS*SLICE_W-1:0] ref_pos,
    input  logic                    learn,
    output logic                    err,
    output logic [NPOS-1:0]         loc
);
    logic [NPOS-1:0] miss;
    logic            total_bad;

    for (genvar k = 0; k < NPOS; k++) begin : g_bit
        assign miss[k] = sum_pos[k*SLICE_W +: SLICE_W] != ref_pos[k*SLICE_W +: SLICE_W];
    end

    assign total_bad = (sum_total != ref_total);
    assign err       = total_bad && !learn;
    assign loc       = err ? miss : '0;
endmodule

// File: rtl/csum_locator.sv
module csum_locator #(
    parameter int BANK_W  = 2,
    parameter int WORD_W  = 4,
    parameter int DATA_W  = 36,
    parameter int SLICE_W = 6,
    parameter int NPOS    = BANK_W + WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    learn,
    output logic [BANK_W-1:0]       mem_sel,
    output logic [WORD_W-1:0]       mem_addr,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic [DATA_W-1:0]       ref_total,
    input  logic [NPOS*SLICE_W-1:0] ref_pos,
    output logic [DATA_W-1:0]       sum_total,
    output logic [NPOS*SLICE_W-1:0] sum_pos,
    output logic                    done,
    output logic                    error,
    output logic [NPOS-1:0]         bad_loc
);
    typedef struct packed {
        logic [DATA_W-1:0]             total;
        logic [NPOS-1:0][SLICE_W-1:0]  pos;
        logic                          learn;
        logic                          done;
        logic                          error;
        logic [NPOS-1:0]               loc;
    } acc_t;

    acc_t st_d, st_q;

    logic [NPOS-1:0]    rd_loc;
    logic               acc_en;
    logic [NPOS-1:0]    acc_addr;
    logic               clr;
    logic               fin;
    logic               scanning;
    logic [SLICE_W-1:0] folded;
    logic               verdict_err;
    logic [NPOS-1:0]    verdict_loc;
    logic               learn_lat;

    csum_seq #(.ADDR_W(NPOS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_addr  (rd_loc),
        .acc_en   (acc_en),
        .acc_addr (acc_addr),
        .clr      (clr),
        .fin      (fin),
        .scanning (scanning)
    );

    csum_fold #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_fold (
        .word  (mem_rdata),
        .slice (folded)
    );

    csum_locate #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .NPOS(NPOS)) u_locate (
        .sum_total (st_q.total),
        .ref_total (ref_total),
        .sum_pos   (st_q.pos),
        .ref_pos   (ref_pos),
        .learn     (st_q.learn),
        .err       (verdict_err),
        .loc       (verdict_loc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d.total = '0;
            st_d.pos   = '0;
            st_d.learn = learn;
            st_d.error = 1'b0;
            st_d.loc   = '0;
        end else if (acc_en) begin
            st_d.total = st_q.total ^ mem_rdata;
            for (int k = 0; k < NPOS; k++) begin
                if (acc_addr[k]) begin
                    st_d.pos[k] = st_q.pos[k] ^ folded;
                end
            end
        end else if (fin) begin
            st_d.done  = 1'b1;
            st_d.error = verdict_err;
            st_d.loc   = verdict_loc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign {mem_sel, mem_addr} = rd_loc;
    assign sum_total = st_q.total;
    assign sum_pos   = st_q.pos;
    assign done      = st_q.done;
    assign error     = st_q.error;
    assign bad_loc   = st_q.loc;
    assign learn_lat = st_q.learn;
endmodule

// File: rtl/csum_locator_chk.sv
module csum_locator_chk #(
    parameter int BANK_W = 2,
    parameter int WORD_W = 4,
    parameter int DATA_W = 36,
    parameter int NPOS   = BANK_W + WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [BANK_W-1:0] mem_sel,
    input logic [WORD_W-1:0] mem_addr,
    input logic [DATA_W-1:0] sum_total,
    input logic [DATA_W-1:0] ref_total,
    input logic              done,
    input logic              error,
    input logic [NPOS-1:0]   bad_loc,
    input logic              scanning,
    input logic              learn_lat
);
    logic [NPOS-1:0] cur_loc;
    assign cur_loc = {mem_sel, mem_addr};

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && $past(scanning)) |-> (cur_loc == $past(cur_loc) + NPOS'(1)));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_clean_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (sum_total == ref_total)) |-> (!error && (bad_loc == '0)));

    assert_fail_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !learn_lat && (sum_total != ref_total)) |-> error);

    assert_learn_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && learn_lat) |-> (!error && (bad_loc == '0)));

    assert_verdict_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |-> ($stable(error) && $stable(bad_loc)));
endmodule

bind csum_locator csum_locator_chk #(
    .BANK_W (BANK_W),
    .WORD_W (WORD_W),
    .DATA_W (DATA_W),
    .NPOS   (NPOS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_sel   (mem_sel),
    .mem_addr  (mem_addr),
    .sum_total (sum_total),
    .ref_total (ref_total),
    .done      (done),
    .error     (error),
    .bad_loc   (bad_loc),
    .scanning  (scanning),
    .learn_lat (learn_lat)
);

// File: tb/csum_locator_bench.sv
module csum_locator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W  = 2;
    localparam int WORD_W  = 4;
    localparam int DATA_W  = 36;
    localparam int SLICE_W = 6;
    localparam int NPOS    = BANK_W + WORD_W;
    localparam int NW      = 1 << NPOS;
    localparam int PW      = NPOS * SLICE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              learn = 1'b0;
    logic [BANK_W-1:0] mem_sel;
    logic [WORD_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [DATA_W-1:0] ref_total = '0;
    logic [PW-1:0]     ref_pos = '0;
    logic [DATA_W-1:0] sum_total;
    logic [PW-1:0]     sum_pos;
    logic              done;
    logic              error;
    logic [NPOS-1:0]   bad_loc;

    logic [DATA_W-1:0] mem [NW];

    int n_chk  = 0;
    int n_fail = 0;

    int              r_lat;
    bit              r_addr_ok;
    bit              r_pulse_ok;
    logic            r_err;
    logic [NPOS-1:0] r_loc;
    logic            r_err_early;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) mem_rdata <= mem[{mem_sel, mem_addr}];

    csum_locator u_csum_locator (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .learn     (learn),
        .mem_sel   (mem_sel),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .ref_total (ref_total),
        .ref_pos   (ref_pos),
        .sum_total (sum_total),
        .sum_pos   (sum_pos),
        .done      (done),
        .error     (error),
        .bad_loc   (bad_loc)
    );

    function automatic logic [SLICE_W-1:0] fold_w(logic [DATA_W-1:0] w);
        logic [SLICE_W-1:0] r = '0;
        for (int i = 0; i < DATA_W / SLICE_W; i++) r ^= w[i*SLICE_W +: SLICE_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] exp_total();
        logic [DATA_W-1:0] r = '0;
        for (int a = 0; a < NW; a++) r ^= mem[a];
        return r;
    endfunction

    function automatic logic [PW-1:0] exp_pos();
        logic [PW-1:0] r = '0;
        for (int a = 0; a < NW; a++)
            for (int k = 0; k < NPOS; k++)
                if (a[k]) r[k*SLICE_W +: SLICE_W] ^= fold_w(mem[a]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_random();
        for (int a = 0; a < NW; a++) mem[a] = DATA_W'({$urandom(), $urandom()});
    endtask

    // runs one scan; inj >= 0 pulses start again that many cycles into the scan
    task automatic run_scan(input logic lrn, input int inj);
        @(negedge clk);
        start = 1'b1;
        learn = lrn;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        r_lat = -1;
        r_addr_ok = 1'b1;
        r_err_early = error;
        for (int j = 0; j < 4 * NW; j++) begin
            start = (j == inj);
            if (j < NW && {mem_sel, mem_addr} != NPOS'(j)) r_addr_ok = 1'b0;
            if (done) begin
                r_lat = j;
                break;
            end
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        r_err = error;
        r_loc = bad_loc;
        @(negedge clk);
        r_pulse_ok = !done;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] saved;
        int a;
        int b;
        void'($urandom(32'd2024));
        fill_random();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !error && bad_loc == '0, "R1", "reset outputs",
            {done, error, bad_loc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !error && bad_loc == '0, "R1", "after release",
            {done, error, bad_loc}, 0);

        for (int img = 0; img < 3; img++) begin
            if (img > 0) fill_random();
            // learn pass: sums, order, latency
            run_scan(1'b1, -1);
            chk(r_addr_ok, "R2", "address order", r_addr_ok, 1);
            chk(r_lat == NW + 2, "R3", "done latency", r_lat, NW + 2);
            chk(r_pulse_ok, "R3", "done width", !r_pulse_ok, 0);
            chk(sum_total == exp_total(), "R4", "total sum", sum_total, exp_total());
            chk(sum_pos == exp_pos(), "R5", "positional sums", sum_pos, exp_pos());
            chk(!r_err && r_loc == '0, "R8", "learn verdict", {r_err, r_loc}, 0);
            ref_total = sum_total;
            ref_pos   = sum_pos;

            // R6: clean image against its own sums
            run_scan(1'b0, -1);
            chk(!r_err && r_loc == '0, "R6", "clean verdict", {r_err, r_loc}, 0);

            // R7: single-bit damage at random and corner locations
            for (int t = 0; t < 6; t++) begin
                a = (t == 0) ? 0 : (t == 1) ? NW - 1 : int'($urandom_range(NW - 1, 0));
                b = int'($urandom_range(DATA_W - 1, 0));
                saved = mem[a];
                mem[a][b] = ~mem[a][b];
                run_scan(1'b0, -1);
                chk(r_err, "R7", "error flag", r_err, 1);
                chk(r_loc == NPOS'(a), "R7", "located word", r_loc, a);
                repeat (3) @(negedge clk);
                // R10: verdict holds after done
                chk(error == r_err && bad_loc == r_loc, "R10", "verdict held",
                    {error, bad_loc}, {r_err, r_loc});
                mem[a] = saved;
                run_scan(1'b0, -1);
                // R10: accepted start cleared the previous error
                chk(!r_err_early, "R10", "cleared at start", r_err_early, 0);
                chk(!r_err, "R6", "restored image", r_err, 0);
            end
        end

        // R6: positional references wrong but total matches
        ref_pos[2*SLICE_W] = ~ref_pos[2*SLICE_W];
        run_scan(1'b0, -1);
        chk(!r_err && r_loc == '0, "R6", "positional ignored", {r_err, r_loc}, 0);
        ref_pos[2*SLICE_W] = ~ref_pos[2*SLICE_W];

        // R8: learn over a damaged image
        saved = mem[37];
        mem[37][5] = ~mem[37][5];
        run_scan(1'b1, -1);
        chk(!r_err && r_loc == '0, "R8", "learn suppresses", {r_err, r_loc}, 0);
        chk(sum_total == exp_total(), "R4", "damaged total", sum_total, exp_total());
        chk(sum_pos == exp_pos(), "R5", "damaged positional", sum_pos, exp_pos());

        // R9: extra start mid-scan
        run_scan(1'b0, 10);
        chk(r_lat == NW + 2, "R9", "latency with extra start", r_lat, NW + 2);
        chk(r_err && r_loc == NPOS'(37), "R9", "result with extra start",
            {r_err, r_loc}, {1'b1, NPOS'(37)});
        mem[37] = saved;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule